// File: doc/BRIEF.md
# Dual-Mode Interrupt Status Combiner

This block keeps four sticky interrupt status bits for a two-channel storage controller and folds them into one interrupt output. Each channel owns two bits: a command-completion interrupt bit and a descriptor-list-finished bit. Hardware raises a bit with a one-cycle set pulse, and software lowers it with a write-one-to-clear strobe. The current bits are always readable on the status port.

The output works in one of two modes, picked by `msg_mode`. In wire mode a level-sensitive interrupt line is high while any bit is pending. In message mode the line is held low. Instead, a one-clock message request is raised whenever the pending set changes in a way that the interrupt handler must see again. That covers a first bit arriving, a further bit arriving, a partial clear, and a clear that lands together with a set. Building the message and running the bus transaction are left to a downstream unit.

Top module: `irq_dual_mode_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `status`, `irq_wire` and `msg_req` are all 0.
- R2: A 1 on `hw_set[i]` at a clock edge makes `status[i]` 1 from that edge on, and the bit stays 1 until it is cleared. Bit index is channel*2 + kind, with kind 0 the completion bit and kind 1 the list-finished bit.
- R3: A 1 on `sw_clr[i]` at a clock edge, with `hw_set[i]` low, makes `status[i]` 0.
- R4: When `hw_set[i]` and `sw_clr[i]` are both 1 at the same edge, `status[i]` is 1 after that edge.
- R5: With `msg_mode` = 0, `irq_wire` is 1 exactly when `status` is nonzero, and `msg_req` stays 0.
- R6: With `msg_mode` = 1, `irq_wire` is 0 whatever `status` holds.
- R7: In message mode, an edge that takes `status` from all-zero to nonzero raises `msg_req` for the following cycle.
- R8: In message mode, setting a bit that was 0 while other bits are pending raises `msg_req`. Setting a bit that is already 1, with no clear, raises nothing.
- R9: In message mode, clearing some but not all pending bits raises `msg_req`.
- R10: No `msg_req` follows an edge after which `status` is all-zero. No `msg_req` follows a clear that hits only bits that are already 0.
- R11: In message mode, a clear of pending bits at the same edge as a set raises `msg_req`.
- R12: `msg_req` is high for exactly one cycle per triggering edge. It becomes visible in the same cycle as the status change that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_mode | input | 1 | 1 selects message mode, 0 selects wire mode |
| hw_set | input | 4 | Per-bit hardware set pulses |
| sw_clr | input | 4 | Per-bit write-one-to-clear strobes |
| status | output | 4 | Current sticky status bits |
| irq_wire | output | 1 | Level interrupt line, wire mode only |
| msg_req | output | 1 | One-cycle message request, message mode only |

## Verification
If a status bit is wrong, it shows on the `status` port one cycle after the strobe that should have changed it. In wire mode the same fault also reaches `irq_wire` in that cycle. A wrong trigger decision shows up as a missing or extra `msg_req` in that same cycle, so a reference model that steps once per clock catches it without delay. The bench walks through every table situation in both modes, and also covers set-over-clear priority, re-setting a bit that is already set, and clears aimed at empty bits. Each of these would otherwise hide a priority or edge-detection fault.

// File: rtl/irq_mm_pkg.sv
package irq_mm_pkg;
    parameter int NUM_CH      = 2;
    parameter int BITS_PER_CH = 2;
    localparam int NBITS      = NUM_CH * BITS_PER_CH;

    typedef struct packed {
        logic [NBITS-1:0] status;
    } bank_state_t;

    typedef struct packed {
        logic msg_req;
    } trig_state_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NBITS = irq_mm_pkg::NBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] hw_set,
    input  logic [NBITS-1:0] sw_clr,
    output logic [NBITS-1:0] status_q,
    output logic [NBITS-1:0] status_nxt
);
    typedef struct packed {
        logic [NBITS-1:0] status;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NBITS; i++) begin
            if (hw_set[i])
                st_d.status[i] = 1'b1;      // set wins over clear
            else if (sw_clr[i])
                st_d.status[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q   = st_q.status;
    assign status_nxt = st_d.status;

    for (genvar g = 0; g < NBITS; g++) begin : g_chk
        p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(hw_set[g])) |-> status_q[g]);
        p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(sw_clr[g]) && !$past(hw_set[g])) |-> !status_q[g]);
    end
endmodule

// File: rtl/irq_msg_trigger.sv
module irq_msg_trigger #(
    parameter int NBITS = irq_mm_pkg::NBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_mode,
    input  logic [NBITS-1:0] cur_status,
    input  logic [NBITS-1:0] nxt_status,
    input  logic [NBITS-1:0] hw_set,
    input  logic [NBITS-1:0] sw_clr,
    output logic             msg_req
);
    typedef struct packed {
        logic req;
    } tr_t;

    tr_t tr_d, tr_q;
    logic fresh_bit, pending_cut, still_pending;

    always_comb begin
        fresh_bit     = |(hw_set & ~cur_status);
        pending_cut   = |(sw_clr & cur_status);
        still_pending = |nxt_status;
        tr_d.req      = msg_mode && still_pending && (fresh_bit || pending_cut);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign msg_req = tr_q.req;

    p_msg_only_in_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> $past(msg_mode));
endmodule

// File: rtl/irq_dual_mode_gen.sv
module irq_dual_mode_gen #(
    parameter int NUM_CH      = irq_mm_pkg::NUM_CH,
    parameter int BITS_PER_CH = irq_mm_pkg::BITS_PER_CH,
    localparam int NBITS      = NUM_CH * BITS_PER_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_mode,
    input  logic [NBITS-1:0] hw_set,
    input  logic [NBITS-1:0] sw_clr,
    output logic [NBITS-1:0] status,
    output logic             irq_wire,
    output logic             msg_req
);
    logic [NBITS-1:0] st_q, st_nxt;

    irq_status_bank #(.NBITS(NBITS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_set     (hw_set),
        .sw_clr     (sw_clr),
        .status_q   (st_q),
        .status_nxt (st_nxt)
    );

    irq_msg_trigger #(.NBITS(NBITS)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_mode   (msg_mode),
        .cur_status (st_q),
        .nxt_status (st_nxt),
        .hw_set     (hw_set),
        .sw_clr     (sw_clr),
        .msg_req    (msg_req)
    );

    always_comb begin
        status   = st_q;
        irq_wire = !msg_mode && (st_q != '0);
    end

    p_wire_low_in_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_mode |-> !irq_wire);
    p_wire_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_mode && status != '0) |-> irq_wire);
    p_no_msg_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !msg_req);
    p_set_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hw_set != '0)) |-> (status != '0));
endmodule

// File: tb/irq_dual_mode_gen_test.sv
module irq_dual_mode_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_mode = 1'b0;
    logic [N-1:0] hw_set = '0;
    logic [N-1:0] sw_clr = '0;
    logic [N-1:0] status;
    logic irq_wire, msg_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit model_bits [N];

    irq_dual_mode_gen uut (
        .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
        .hw_set(hw_set), .sw_clr(sw_clr),
        .status(status), .irq_wire(irq_wire), .msg_req(msg_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_word();
        int w = 0;
        for (int i = 0; i < N; i++) if (model_bits[i]) w += (1 << i);
        return w;
    endfunction

    // one clock: drive at negedge, update model, compare at next negedge
    task automatic step(input logic [N-1:0] s, input logic [N-1:0] c, input string req);
        bit was_any, now_any, grew, cut;
        bit exp_msg;
        hw_set = s; sw_clr = c;
        was_any = (model_word() != 0);
        grew = 0; cut = 0;
        for (int i = 0; i < N; i++) begin
            if (s[i] && !model_bits[i]) grew = 1;
            if (c[i] && model_bits[i]) cut = 1;
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (s[i]) model_bits[i] = 1;
            else if (c[i]) model_bits[i] = 0;
        end
        now_any = (model_word() != 0);
        exp_msg = msg_mode && now_any && (grew || cut);
        if (was_any) begin end
        @(negedge clk);
        hw_set = '0; sw_clr = '0;
        check({req, " status"}, int'(status), model_word());
        check({req, " wire"}, int'(irq_wire), (!msg_mode && now_any) ? 1 : 0);
        check({req, " msg"}, int'(msg_req), exp_msg ? 1 : 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < N; i++) model_bits[i] = 0;
        hw_set = '0; sw_clr = '0;
        repeat (3) @(negedge clk);
        check("R1 status in reset", int'(status), 0);
        check("R1 wire in reset", int'(irq_wire), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 msg after reset", int'(msg_req), 0);
        check("R1 status after reset", int'(status), 0);
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            msg_mode = logic'(m);
            do_reset();
            step(4'b0000, 4'b0000, "R10 idle");
            step(4'b0001, 4'b0000, "R7 first bit");
            step(4'b0000, 4'b0000, "R12 pulse ends");
            step(4'b1000, 4'b0000, "R8 new bit");
            step(4'b0001, 4'b0000, "R8 reset bit no msg");
            step(4'b0000, 4'b0001, "R9 partial clear");
            step(4'b0000, 4'b0100, "R10 clear empty bit");
            step(4'b0010, 4'b1000, "R11 clear with set");
            step(4'b0010, 4'b0010, "R4 set beats clear");
            step(4'b0100, 4'b0000, "R2 channel1 kind0");
            step(4'b0000, 4'b0110, "R3 clear all");
            step(4'b0000, 4'b0000, "R10 stays quiet");
            step(4'b1001, 4'b0000, "R5 wire/msg two bits");
            // mode flip with bits pending: wire follows mode at once
            msg_mode = ~msg_mode;
            #1;
            check("R6 wire after mode flip", int'(irq_wire), msg_mode ? 0 : 1);
            msg_mode = ~msg_mode;
            #1;
            check("R5 wire after mode restore", int'(irq_wire), msg_mode ? 0 : 1);
            step(4'b0000, 4'b1001, "R10 full clear");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule